// File: doc/BRIEF.md
# Bidirectional Digital Port with Toggle-by-Write

This block controls a bank of general-purpose pins, eight by default. Each pin has a direction bit and an output bit. Together with a global pull-up kill input, these two bits decide whether the pin is driven high, driven low, weakly pulled up, or left floating. The block does not model the pad itself. It produces three per-pin control vectors (drive enable, drive level, pull-up enable) for an external pad, and it takes the raw pad levels back in.

Software reaches three registers through a small bus: a register select, a write strobe, write data and combinational read data. Reading the pin register returns the pad level after it has crossed a multi-flop synchronizer, whatever the direction setting is, so a driven pin reads back its own level. Writing ones to the pin register flips the matching output bits and leaves the others alone. This lets a driver flip a pin without a read-modify-write.

Top module: `gpio_toggle_port`

## Requirements
- R1: After reset, the direction and output registers are all zero, so every pin has drive enable 0, drive level 0 and pull-up 0.
- R2: A write with select 1 loads the direction register and a write with select 2 loads the output register at the next rising clock edge. Reading select 1 or 2 returns that register.
- R3: A write with select 0 inverts each output-register bit whose write-data bit is 1 and leaves bits written with 0 unchanged, whatever the direction bits are.
- R4: A pin with direction 0 and output 0 has drive enable 0, drive level 0 and pull-up 0.
- R5: A pin with direction 0 and output 1 has pull-up enabled exactly when the global pull-up disable input is 0. Its drive enable is 0.
- R6: A pin with direction 1 has drive enable 1 and drive level equal to its output bit. Its pull-up is 0 whatever the global disable is.
- R7: Reading select 0 returns the pad input level sampled two rising edges earlier, for every direction setting.
- R8: Select 3 reads as all zeros, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 2 | Register select: 0 pin, 1 direction, 2 output, 3 unused |
| we | input | 1 | Write strobe for the selected register |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Combinational read data of the selected register |
| pull_off | input | 1 | Global pull-up disable, 1 forces all pull-ups off |
| pad_in | input | WIDTH | Raw pad levels, asynchronous to clk |
| pad_oe | output | WIDTH | Per-pin drive enable |
| pad_out | output | WIDTH | Per-pin drive level, 0 when not driving |
| pad_pu | output | WIDTH | Per-pin pull-up enable |

## Verification
Register writes, and therefore the pad controls, change one rising edge after the strobe. Pin-register read data follows a pad change after exactly two rising edges. The pull-up vector reacts to the global disable in the same cycle, with no edge in between. The bench drives every input at the falling edge and checks shortly afterwards. Its model advances the register state and a two-deep history of pad values once per rising edge. Each comparison therefore sees the state that the preceding edges produced, and the combinational read path is judged against the select value just driven.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   typedef enum logic [1:0] {
      SEL_PIN  = 2'd0,
      SEL_DIR  = 2'd1,
      SEL_OUT  = 2'd2,
      SEL_NONE = 2'd3
   } port_sel_e;

   typedef struct packed {
      logic oe;
      logic lvl;
      logic pu;
   } pad_ctl_t;

   function automatic pad_ctl_t decode_pin(input logic dir, input logic outb, input logic kill);
      pad_ctl_t c;
      c.oe  = dir;
      c.lvl = dir & outb;
      c.pu  = ~dir & outb & ~kill;
      return c;
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk) stage_q[0] <= d_async;

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) stage_q[s] <= stage_q[s-1];
   end

   assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_port_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  port_sel_e        sel,
   input  logic             we,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] out_q
);
   logic [WIDTH-1:0] out_d;

   always_comb begin
      out_d = out_q;
      if (we) begin
         unique case (sel)
            SEL_OUT: out_d = wdata;
            SEL_PIN: out_d = out_q ^ wdata;
            default: out_d = out_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= '0;
         out_q <= '0;
      end else begin
         if (we && sel == SEL_DIR) dir_q <= wdata;
         out_q <= out_d;
      end
   end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
   import gpio_port_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] out_q,
   input  logic             pull_off,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_pu
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      pad_ctl_t ctl;
      assign ctl        = decode_pin(dir_q[i], out_q[i], pull_off);
      assign pad_oe[i]  = ctl.oe;
      assign pad_out[i] = ctl.lvl;
      assign pad_pu[i]  = ctl.pu;
   end
endmodule

// File: rtl/gpio_toggle_port.sv
module gpio_toggle_port
   import gpio_port_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       sel,
   input  logic             we,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata,
   input  logic             pull_off,
   input  logic [WIDTH-1:0] pad_in,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_pu
);
   initial begin
      assert (WIDTH >= 1 && WIDTH <= 64) else $error("WIDTH out of range");
      assert (SYNC_STAGES >= 2 && SYNC_STAGES <= 4) else $error("SYNC_STAGES out of range");
   end

   port_sel_e        sel_e;
   logic [WIDTH-1:0] dir_q;
   logic [WIDTH-1:0] out_q;
   logic [WIDTH-1:0] pin_sync;

   assign sel_e = port_sel_e'(sel);

   gpio_regfile #(.WIDTH(WIDTH)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (sel_e),
      .we    (we),
      .wdata (wdata),
      .dir_q (dir_q),
      .out_q (out_q)
   );

   gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .d_async (pad_in),
      .q_sync  (pin_sync)
   );

   gpio_pad_ctrl #(.WIDTH(WIDTH)) u_pads (
      .dir_q    (dir_q),
      .out_q    (out_q),
      .pull_off (pull_off),
      .pad_oe   (pad_oe),
      .pad_out  (pad_out),
      .pad_pu   (pad_pu)
   );

   always_comb begin
      unique case (sel_e)
         SEL_PIN: rdata = pin_sync;
         SEL_DIR: rdata = dir_q;
         SEL_OUT: rdata = out_q;
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_toggle_port_chk.sv
module gpio_toggle_port_chk #(
   parameter int WIDTH       = 8,
   parameter int SYNC_STAGES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       sel,
   input logic             we,
   input logic [WIDTH-1:0] wdata,
   input logic [WIDTH-1:0] rdata,
   input logic             pull_off,
   input logic [WIDTH-1:0] pad_in,
   input logic [WIDTH-1:0] pad_oe,
   input logic [WIDTH-1:0] pad_out,
   input logic [WIDTH-1:0] pad_pu,
   input logic [WIDTH-1:0] out_q
);
   assert_dir_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == 2'd1) |=> (pad_oe == $past(wdata)));

   assert_out_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == 2'd2) |=> (out_q == $past(wdata)));

   assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == 2'd0) |=> (out_q == ($past(out_q) ^ $past(wdata))));

   assert_no_pu_kill_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pull_off |-> (pad_pu == '0));

   assert_no_pu_on_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & pad_pu) == '0));

   assert_quiet_undriven_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_out & ~pad_oe) == '0));

   assert_unused_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == 2'd3) |=> $stable(pad_oe) && (out_q == $past(out_q)));

   if (SYNC_STAGES == 2) begin : g_lat
      assert_pin_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (sel == 2'd0) |-> (rdata == $past(pad_in, 2)));
   end
endmodule

bind gpio_toggle_port gpio_toggle_port_chk #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sel      (sel),
   .we       (we),
   .wdata    (wdata),
   .rdata    (rdata),
   .pull_off (pull_off),
   .pad_in   (pad_in),
   .pad_oe   (pad_oe),
   .pad_out  (pad_out),
   .pad_pu   (pad_pu),
   .out_q    (out_q)
);

// File: tb/gpio_toggle_port_bench.sv
module gpio_toggle_port_bench;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   sel = 2'd0;
   logic         we = 1'b0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] rdata;
   logic         pull_off = 1'b0;
   logic [W-1:0] pad_in = '0;
   logic [W-1:0] pad_oe, pad_out, pad_pu;

   int n_cmp = 0;
   int n_bad = 0;

   logic [W-1:0] m_dir = '0, m_out = '0, m_s1 = '0, m_s2 = '0;

   always #4 clk = ~clk;

   gpio_toggle_port u_gpio_toggle_port (
      .clk(clk), .rst_n(rst_n), .sel(sel), .we(we), .wdata(wdata), .rdata(rdata),
      .pull_off(pull_off), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
   );

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [W-1:0] exp_pu(input logic [W-1:0] d, input logic [W-1:0] o, input logic k);
      return k ? '0 : (~d & o);
   endfunction

   // Drive one cycle of stimulus at the falling edge, check, then advance the model
   task automatic step(input logic [1:0] s, input logic w, input logic [W-1:0] d,
                       input logic k, input logic [W-1:0] pin);
      @(negedge clk);
      sel = s; we = w; wdata = d; pull_off = k; pad_in = pin;
      #1;
      chk("R6 drive enable", pad_oe, m_dir);
      chk("R6 drive level", pad_out, m_dir & m_out);
      chk("R5 pull-up", pad_pu, exp_pu(m_dir, m_out, k));
      case (s)
         2'd0: chk("R7 pin read", rdata, m_s2);
         2'd1: chk("R2 dir read", rdata, m_dir);
         2'd2: chk("R2 out read", rdata, m_out);
         default: chk("R8 unused read", rdata, '0);
      endcase
      if (w) begin
         case (s)
            2'd0: m_out = m_out ^ d;
            2'd1: m_dir = d;
            2'd2: m_out = d;
            default: ;
         endcase
      end
      m_s2 = m_s1;
      m_s1 = pin;
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1: reset state
      #1;
      chk("R1 oe after reset", pad_oe, '0);
      chk("R1 out after reset", pad_out, '0);
      chk("R1 pu after reset", pad_pu, '0);
      step(2'd1, 0, '0, 0, '0);
      step(2'd2, 0, '0, 0, '0);

      // R4 -> R5 -> R6: tri-state, pull-up intermediate, then output high on bit 0
      step(2'd2, 1, 8'h01, 0, '0);
      step(2'd1, 0, '0, 0, '0);
      #1 chk("R5 pull-up intermediate", pad_pu, 8'h01);
      step(2'd1, 1, 8'h01, 0, '0);
      step(2'd2, 0, '0, 1, '0);
      #1 chk("R6 output high", {pad_oe[0], pad_out[0], pad_pu[0]}, 8'h06);
      step(2'd1, 1, 8'h00, 1, '0);
      #1 chk("R5 pull-up killed", pad_pu, 8'h00);

      // R3: toggle with mixed directions, then R8 write ignored
      step(2'd1, 1, 8'hF0, 0, '0);
      step(2'd2, 1, 8'h3C, 0, '0);
      step(2'd0, 1, 8'h99, 0, '0);
      step(2'd2, 0, '0, 0, '0);
      #1 chk("R3 toggle result", rdata, 8'hA5);
      step(2'd3, 1, 8'hFF, 0, '0);
      step(2'd2, 0, '0, 0, '0);
      #1 chk("R8 write ignored", rdata, 8'hA5);

      // R7: pad change visible after two edges, also for driven pins
      step(2'd0, 0, '0, 0, 8'h5A);
      step(2'd0, 0, '0, 0, 8'h5A);
      #1 chk("R7 one edge late", rdata, 8'h00);
      step(2'd0, 0, '0, 0, 8'h5A);
      #1 chk("R7 two edges", rdata, 8'h5A);

      // Random mix
      for (int i = 0; i < 400; i++) begin
         step(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), W'($urandom),
              1'($urandom_range(0, 1)), W'($urandom));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule